// File: doc/BRIEF.md
# Speculative Reorder Buffer

The block keeps in-flight instructions in program order while they execute out of order. It is a circular queue of slots. When an instruction issues, the block takes the slot at the tail and stores the instruction's destination register, its PC and its kind. The kind is a plain operation, a store, or a branch with the direction it was predicted to take. The slot number goes back to the issuer as the instruction's tag. Each execution unit later returns a result under that tag. A result carries the value, a fault flag and, for a branch, the direction actually taken. It also carries an auxiliary word: the target address of a branch, or the memory address of a store.

Retirement happens only at the head slot, and only once its result is present. A plain operation writes the register file. A store writes memory. A correctly predicted branch leaves with no side effect. Two cases empty the whole buffer and pulse a flush with a restart PC: a mispredicted branch, and any faulting instruction. Exceptions are therefore raised only when the faulting instruction is the oldest one, and younger work that has already finished is thrown away. All retirement outputs are registered.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `iss_ready` follows `rs_free`, `iss_tag` is 0, and `rf_we`, `st_we`, `flush` and `exc` are all 0.
- R2: An accepted issue takes the slot numbered `iss_tag`, and `iss_tag` then advances by one, wrapping from 15 to 0.
- R3: `iss_ready` is low while `rs_free` is low or all 16 slots are occupied, and an issue offered while it is low is not recorded.
- R4: A head entry of kind 0 (plain) that completed without fault retires with `rf_we` high, `rf_addr` equal to its destination and `rf_data` equal to its result, on the second rising edge after its completion is presented.
- R5: A head entry of kind 1 (store) that completed without fault retires with `st_we` high, `st_addr` equal to its auxiliary word and `st_data` equal to its result, and no register write.
- R6: A head entry of kind 2 (branch) whose resolved direction matches its prediction retires with no write, no flush and no exception.
- R7: A head branch whose resolved direction differs from its prediction pulses `flush` with `redirect_pc` equal to its auxiliary word if taken, or its PC plus 4 if not taken. Every entry is discarded and `iss_tag` returns to 0.
- R8: A head entry that completed with `cmp_fault` set pulses `exc` together with `flush`, with `redirect_pc` equal to that entry's PC. It makes no register or memory write.
- R9: A completion addressed to a slot that holds no live entry, such as one emptied by a flush, has no effect on any later retirement.
- R10: While the head is about to flush, `iss_ready` is low, and an issue offered in that cycle is dropped.
- R11: Entries retire strictly in issue order, at most one per cycle. A finished entry waits while any older entry is unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_free | input | 1 | A reservation station is available |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | 0 plain, 1 store, 2 branch |
| iss_pred | input | 1 | Predicted branch direction (1 taken) |
| iss_dest | input | 5 | Destination register |
| iss_pc | input | 32 | Instruction PC |
| iss_ready | output | 1 | Issue accepted this cycle if requested |
| iss_tag | output | 4 | Slot given to the issuing instruction |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | 4 | Slot being completed |
| cmp_data | input | 32 | Result value or store data |
| cmp_fault | input | 1 | Instruction faulted |
| cmp_taken | input | 1 | Resolved branch direction |
| cmp_aux | input | 32 | Branch target or store address |
| rf_we | output | 1 | Register write pulse |
| rf_addr | output | 5 | Register written |
| rf_data | output | 32 | Value written |
| st_we | output | 1 | Memory store pulse |
| st_addr | output | 32 | Store address |
| st_data | output | 32 | Store data |
| flush | output | 1 | Buffer emptied, restart fetch |
| redirect_pc | output | 32 | Restart PC when flush is high |
| exc | output | 1 | Flush was caused by a fault |

## Verification
`iss_ready` is combinational and responds within the cycle. The bench reads it one time step after it changes the inputs, at the falling edge. `iss_tag` changes on the rising edge that accepts an issue. A completion is stored on the first rising edge after it is presented, and the head's retirement shows on the outputs after the second. The bench therefore presents each completion for one cycle and samples the retirement ports two falling edges later. When a chain of finished entries is waiting behind the head, the bench expects one retirement per falling edge after that. Every retirement output is a single-cycle pulse, so the bench samples each one on exactly the falling edge where it is due.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    OP_ALU    = 2'd0,
    OP_STORE  = 2'd1,
    OP_BRANCH = 2'd2,
    OP_RSVD   = 2'd3
  } op_kind_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic          retire,
  input  logic          flush,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] cnt,
  output logic          full
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (alloc)  tail <= step(tail);
      if (retire) head <= step(head);
      case ({alloc, retire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign full = (cnt == CW'(DEPTH));
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH),
  parameter int RW    = 5,
  parameter int XW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          alloc,
  input  logic [PW-1:0] tail,
  input  logic [1:0]    a_kind,
  input  logic          a_pred,
  input  logic [RW-1:0] a_dest,
  input  logic [XW-1:0] a_pc,
  input  logic          cmp_valid,
  input  logic [PW-1:0] cmp_tag,
  input  logic [XW-1:0] cmp_data,
  input  logic          cmp_fault,
  input  logic          cmp_taken,
  input  logic [XW-1:0] cmp_aux,
  input  logic          retire,
  input  logic [PW-1:0] head,
  output logic          h_vld,
  output logic          h_done,
  output op_kind_t      h_kind,
  output logic          h_pred,
  output logic [RW-1:0] h_dest,
  output logic [XW-1:0] h_pc,
  output logic [XW-1:0] h_data,
  output logic          h_fault,
  output logic          h_taken,
  output logic [XW-1:0] h_aux
);
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] done;
  op_kind_t      kind_m  [DEPTH];
  logic          pred_m  [DEPTH];
  logic [RW-1:0] dest_m  [DEPTH];
  logic [XW-1:0] pc_m    [DEPTH];
  logic [XW-1:0] data_m  [DEPTH];
  logic          fault_m [DEPTH];
  logic          taken_m [DEPTH];
  logic [XW-1:0] aux_m   [DEPTH];

  logic cmp_hit;
  assign cmp_hit = cmp_valid && vld[cmp_tag];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || flush)                      vld[i] <= 1'b0;
      else if (alloc && tail == PW'(i))      vld[i] <= 1'b1;
      else if (retire && head == PW'(i))     vld[i] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (rst)                               done[i] <= 1'b0;
      else if (alloc && tail == PW'(i))      done[i] <= 1'b0;
      else if (cmp_hit && cmp_tag == PW'(i)) done[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      kind_m[tail] <= op_kind_t'(a_kind);
      pred_m[tail] <= a_pred;
      dest_m[tail] <= a_dest;
      pc_m[tail]   <= a_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (cmp_hit) begin
      data_m[cmp_tag]  <= cmp_data;
      fault_m[cmp_tag] <= cmp_fault;
      taken_m[cmp_tag] <= cmp_taken;
      aux_m[cmp_tag]   <= cmp_aux;
    end
  end

  assign h_vld   = vld[head];
  assign h_done  = done[head];
  assign h_kind  = kind_m[head];
  assign h_pred  = pred_m[head];
  assign h_dest  = dest_m[head];
  assign h_pc    = pc_m[head];
  assign h_data  = data_m[head];
  assign h_fault = fault_m[head];
  assign h_taken = taken_m[head];
  assign h_aux   = aux_m[head];
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int RW = 5,
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_vld,
  input  logic          h_done,
  input  op_kind_t      h_kind,
  input  logic          h_pred,
  input  logic [RW-1:0] h_dest,
  input  logic [XW-1:0] h_pc,
  input  logic [XW-1:0] h_data,
  input  logic          h_fault,
  input  logic          h_taken,
  input  logic [XW-1:0] h_aux,
  output logic          retire,
  output logic          flush_now,
  output logic          rf_we,
  output logic [RW-1:0] rf_addr,
  output logic [XW-1:0] rf_data,
  output logic          st_we,
  output logic [XW-1:0] st_addr,
  output logic [XW-1:0] st_data,
  output logic          flush,
  output logic [XW-1:0] redirect_pc,
  output logic          exc
);
  logic fire, mispred, is_st, is_br;

  assign fire      = h_vld && h_done;
  assign is_st     = (h_kind == OP_STORE);
  assign is_br     = (h_kind == OP_BRANCH);
  assign mispred   = is_br && (h_taken != h_pred);
  assign flush_now = fire && (h_fault || mispred);
  assign retire    = fire && !flush_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we       <= 1'b0;
      st_we       <= 1'b0;
      flush       <= 1'b0;
      exc         <= 1'b0;
      rf_addr     <= '0;
      rf_data     <= '0;
      st_addr     <= '0;
      st_data     <= '0;
      redirect_pc <= '0;
    end else begin
      rf_we <= retire && !is_st && !is_br;
      st_we <= retire && is_st;
      flush <= flush_now;
      exc   <= fire && h_fault;
      if (retire) begin
        rf_addr <= h_dest;
        rf_data <= h_data;
        st_addr <= h_aux;
        st_data <= h_data;
      end
      if (flush_now)
        redirect_pc <= h_fault ? h_pc : (h_taken ? h_aux : h_pc + XW'(4));
    end
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RW    = 5,
  parameter int XW    = 32,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rs_free,
  input  logic          iss_valid,
  input  logic [1:0]    iss_kind,
  input  logic          iss_pred,
  input  logic [RW-1:0] iss_dest,
  input  logic [XW-1:0] iss_pc,
  output logic          iss_ready,
  output logic [PW-1:0] iss_tag,
  input  logic          cmp_valid,
  input  logic [PW-1:0] cmp_tag,
  input  logic [XW-1:0] cmp_data,
  input  logic          cmp_fault,
  input  logic          cmp_taken,
  input  logic [XW-1:0] cmp_aux,
  output logic          rf_we,
  output logic [RW-1:0] rf_addr,
  output logic [XW-1:0] rf_data,
  output logic          st_we,
  output logic [XW-1:0] st_addr,
  output logic [XW-1:0] st_data,
  output logic          flush,
  output logic [XW-1:0] redirect_pc,
  output logic          exc
);
  localparam int CW = PW + 1;

  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;
  logic          full, alloc, retire, flush_now;
  logic          h_vld, h_done, h_pred, h_fault, h_taken;
  op_kind_t      h_kind;
  logic [RW-1:0] h_dest;
  logic [XW-1:0] h_pc, h_data, h_aux;

  assign iss_ready = rs_free && !full && !flush_now;
  assign alloc     = iss_valid && iss_ready;
  assign iss_tag   = tail;

  rob_ptrs #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ptrs (
    .clk(clk), .rst(rst), .alloc(alloc), .retire(retire), .flush(flush_now),
    .head(head), .tail(tail), .cnt(cnt), .full(full)
  );

  rob_store #(.DEPTH(DEPTH), .PW(PW), .RW(RW), .XW(XW)) u_store (
    .clk(clk), .rst(rst), .flush(flush_now), .alloc(alloc), .tail(tail),
    .a_kind(iss_kind), .a_pred(iss_pred), .a_dest(iss_dest), .a_pc(iss_pc),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
    .cmp_fault(cmp_fault), .cmp_taken(cmp_taken), .cmp_aux(cmp_aux),
    .retire(retire), .head(head),
    .h_vld(h_vld), .h_done(h_done), .h_kind(h_kind), .h_pred(h_pred),
    .h_dest(h_dest), .h_pc(h_pc), .h_data(h_data), .h_fault(h_fault),
    .h_taken(h_taken), .h_aux(h_aux)
  );

  rob_retire #(.RW(RW), .XW(XW)) u_retire (
    .clk(clk), .rst(rst),
    .h_vld(h_vld), .h_done(h_done), .h_kind(h_kind), .h_pred(h_pred),
    .h_dest(h_dest), .h_pc(h_pc), .h_data(h_data), .h_fault(h_fault),
    .h_taken(h_taken), .h_aux(h_aux),
    .retire(retire), .flush_now(flush_now),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
    .flush(flush), .redirect_pc(redirect_pc), .exc(exc)
  );
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = PW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cnt,
  input logic          full,
  input logic          alloc,
  input logic          iss_ready,
  input logic [PW-1:0] iss_tag,
  input logic          rf_we,
  input logic          st_we,
  input logic          flush,
  input logic          exc
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  p_full_stalls_r3: assert property (@(posedge clk) disable iff (rst)
    full |-> !iss_ready);

  p_single_action_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, st_we, flush}));

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
    flush |-> (cnt == '0 && iss_tag == '0));

  p_exc_flushes_r8: assert property (@(posedge clk) disable iff (rst)
    exc |-> flush);

  p_flush_drops_issue_r10: assert property (@(posedge clk) disable iff (rst)
    flush |-> !$past(alloc));

  p_retire_step_r11: assert property (@(posedge clk) disable iff (rst)
    ((rf_we || st_we) && !$past(alloc)) |-> (cnt == $past(cnt) - 1'b1));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .full(full), .alloc(alloc),
  .iss_ready(iss_ready), .iss_tag(iss_tag), .rf_we(rf_we), .st_we(st_we),
  .flush(flush), .exc(exc)
);

// File: tb/sim_rob_core.sv
module sim_rob_core;
  logic        clk = 1'b0;
  logic        rst;
  logic        rs_free, iss_valid, iss_pred, iss_ready;
  logic [1:0]  iss_kind;
  logic [4:0]  iss_dest;
  logic [31:0] iss_pc;
  logic [3:0]  iss_tag;
  logic        cmp_valid, cmp_fault, cmp_taken;
  logic [3:0]  cmp_tag;
  logic [31:0] cmp_data, cmp_aux;
  logic        rf_we, st_we, flush, exc;
  logic [4:0]  rf_addr;
  logic [31:0] rf_data, st_addr, st_data, redirect_pc;

  always #5 clk = ~clk;

  rob_core u0 (
    .clk(clk), .rst(rst), .rs_free(rs_free), .iss_valid(iss_valid),
    .iss_kind(iss_kind), .iss_pred(iss_pred), .iss_dest(iss_dest),
    .iss_pc(iss_pc), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
    .cmp_fault(cmp_fault), .cmp_taken(cmp_taken), .cmp_aux(cmp_aux),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
    .flush(flush), .redirect_pc(redirect_pc), .exc(exc)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        pred;
    logic        taken;
    logic        fault;
    logic [4:0]  dest;
    logic [31:0] pc;
    logic [31:0] data;
    logic [31:0] aux;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 5'd3,  32'h0000_1000, 32'hDEAD_0001, 32'h0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 5'd31, 32'h0000_1004, 32'h1234_5678, 32'h0},
    '{2'd1, 1'b0, 1'b0, 1'b0, 5'd0,  32'h0000_1008, 32'hCAFE_F00D, 32'h0000_8000},
    '{2'd2, 1'b1, 1'b1, 1'b0, 5'd0,  32'h0000_100C, 32'h0,         32'h0000_2000},
    '{2'd2, 1'b0, 1'b1, 1'b0, 5'd0,  32'h0000_1010, 32'h0,         32'h0000_3000},
    '{2'd2, 1'b1, 1'b0, 1'b0, 5'd0,  32'h0000_1014, 32'h0,         32'h0000_4000},
    '{2'd0, 1'b0, 1'b0, 1'b1, 5'd7,  32'h0000_1018, 32'h0BAD_0BAD, 32'h0},
    '{2'd1, 1'b0, 1'b0, 1'b1, 5'd0,  32'h0000_101C, 32'h5555_AAAA, 32'h0000_9000}
  };

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done_flag = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_issue(input logic [1:0] k, input logic p,
                          input logic [4:0] d, input logic [31:0] pc);
    iss_kind = k; iss_pred = p; iss_dest = d; iss_pc = pc; iss_valid = 1'b1;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic do_cmp(input logic [3:0] t, input logic [31:0] d,
                        input logic f, input logic tk, input logic [31:0] a);
    cmp_tag = t; cmp_data = d; cmp_fault = f; cmp_taken = tk; cmp_aux = a;
    cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] t0, bt;
    rst = 1'b1; rs_free = 1'b1; iss_valid = 1'b0; iss_kind = '0;
    iss_pred = 1'b0; iss_dest = '0; iss_pc = '0;
    cmp_valid = 1'b0; cmp_tag = '0; cmp_data = '0; cmp_fault = 1'b0;
    cmp_taken = 1'b0; cmp_aux = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", "iss_ready", 32'(iss_ready), 32'd1);
    chk("R1", "iss_tag", 32'(iss_tag), 32'd0);
    chk("R1", "rf_we", 32'(rf_we), 32'd0);
    chk("R1", "st_we", 32'(st_we), 32'd0);
    chk("R1", "flush", 32'(flush), 32'd0);
    chk("R1", "exc", 32'(exc), 32'd0);

    // Vector table: one instruction at a time, retirement two edges after completion
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic is_alu, mis, e_rf, e_st, e_fl;
      logic [31:0] e_pc;
      string rq;
      v = VECS[i];
      t0 = iss_tag;
      do_issue(v.kind, v.pred, v.dest, v.pc);
      do_cmp(t0, v.data, v.fault, v.taken, v.aux);
      @(negedge clk);
      is_alu = (v.kind == 2'd0);
      mis    = (v.kind == 2'd2) && (v.taken != v.pred);
      e_rf   = is_alu && !v.fault;
      e_st   = (v.kind == 2'd1) && !v.fault;
      e_fl   = v.fault || mis;
      e_pc   = v.fault ? v.pc : (v.taken ? v.aux : v.pc + 32'd4);
      rq = v.fault ? "R8" : (mis ? "R7" : (v.kind == 2'd1 ? "R5" :
           (v.kind == 2'd2 ? "R6" : "R4")));
      chk(rq, "rf_we", 32'(rf_we), 32'(e_rf));
      chk(rq, "st_we", 32'(st_we), 32'(e_st));
      chk(rq, "flush", 32'(flush), 32'(e_fl));
      chk(rq, "exc", 32'(exc), 32'(v.fault));
      if (e_rf) begin
        chk(rq, "rf_addr", 32'(rf_addr), 32'(v.dest));
        chk(rq, "rf_data", rf_data, v.data);
      end
      if (e_st) begin
        chk(rq, "st_addr", st_addr, v.aux);
        chk(rq, "st_data", st_data, v.data);
      end
      if (e_fl) begin
        chk(rq, "redirect_pc", redirect_pc, e_pc);
        chk(rq, "iss_tag after flush", 32'(iss_tag), 32'd0);
      end
    end

    // R11 / R2: out-of-order completion, in-order retirement
    t0 = iss_tag;
    do_issue(2'd0, 1'b0, 5'd1, 32'h2000);
    chk("R2", "iss_tag step", 32'(iss_tag), 32'(t0 + 4'd1));
    do_issue(2'd0, 1'b0, 5'd2, 32'h2004);
    do_issue(2'd0, 1'b0, 5'd3, 32'h2008);
    do_cmp(t0 + 4'd2, 32'd300, 1'b0, 1'b0, 32'd0);
    do_cmp(t0 + 4'd1, 32'd200, 1'b0, 1'b0, 32'd0);
    chk("R11", "younger waits rf_we", 32'(rf_we), 32'd0);
    do_cmp(t0, 32'd100, 1'b0, 1'b0, 32'd0);
    chk("R11", "still waiting rf_we", 32'(rf_we), 32'd0);
    @(negedge clk);
    chk("R11", "first rf_addr", 32'(rf_we ? rf_addr : 5'd0), 32'd1);
    @(negedge clk);
    chk("R11", "second rf_addr", 32'(rf_we ? rf_addr : 5'd0), 32'd2);
    chk("R11", "second rf_data", rf_data, 32'd200);
    @(negedge clk);
    chk("R11", "third rf_addr", 32'(rf_we ? rf_addr : 5'd0), 32'd3);
    @(negedge clk);
    chk("R11", "idle rf_we", 32'(rf_we), 32'd0);

    // R3: no reservation station
    rs_free = 1'b0; #1;
    chk("R3", "iss_ready rs busy", 32'(iss_ready), 32'd0);
    @(negedge clk);
    rs_free = 1'b1;

    // R3 / R2 wrap: fill all 16 slots, head is a branch
    bt = iss_tag;
    do_issue(2'd2, 1'b0, 5'd0, 32'h0000_0400);
    for (int k = 1; k < 16; k++) do_issue(2'd0, 1'b0, 5'(k), 32'h500 + 32'(k));
    #1;
    chk("R3", "iss_ready full", 32'(iss_ready), 32'd0);
    chk("R2", "iss_tag wrapped", 32'(iss_tag), 32'(bt));
    do_issue(2'd0, 1'b0, 5'd20, 32'h0000_0600);
    chk("R3", "iss_tag unchanged when full", 32'(iss_tag), 32'(bt));
    do_cmp(bt + 4'd1, 32'd11, 1'b0, 1'b0, 32'd0);
    do_cmp(bt + 4'd2, 32'd12, 1'b0, 1'b0, 32'd0);
    chk("R11", "behind unresolved branch rf_we", 32'(rf_we), 32'd0);
    do_cmp(bt, 32'd0, 1'b0, 1'b1, 32'h0000_0800);
    @(negedge clk);
    chk("R7", "flush", 32'(flush), 32'd1);
    chk("R7", "redirect_pc", redirect_pc, 32'h0000_0800);
    chk("R7", "iss_tag", 32'(iss_tag), 32'd0);
    chk("R7", "rf_we", 32'(rf_we), 32'd0);
    #1;
    chk("R7", "iss_ready after flush", 32'(iss_ready), 32'd1);
    // R9: stale completion to a flushed slot
    do_cmp(bt + 4'd5, 32'd77, 1'b0, 1'b0, 32'd0);
    do_cmp(4'd0, 32'd78, 1'b0, 1'b0, 32'd0);
    @(negedge clk);
    chk("R9", "rf_we stale", 32'(rf_we), 32'd0);
    @(negedge clk);
    chk("R9", "rf_we stale later", 32'(rf_we), 32'd0);
    chk("R9", "iss_tag unchanged", 32'(iss_tag), 32'd0);

    // R10: issue offered while the head flushes is dropped
    do_issue(2'd2, 1'b1, 5'd0, 32'h0000_0200);
    do_cmp(4'd0, 32'd0, 1'b0, 1'b0, 32'h0000_0F00);
    #1;
    chk("R10", "iss_ready during flush", 32'(iss_ready), 32'd0);
    iss_kind = 2'd0; iss_dest = 5'd9; iss_pc = 32'h0000_0300; iss_valid = 1'b1;
    @(negedge clk);
    iss_valid = 1'b0;
    chk("R10", "flush", 32'(flush), 32'd1);
    chk("R7", "redirect not taken", redirect_pc, 32'h0000_0204);
    chk("R10", "iss_tag dropped", 32'(iss_tag), 32'd0);
    do_cmp(4'd0, 32'd99, 1'b0, 1'b0, 32'd0);
    @(negedge clk);
    chk("R10", "dropped issue rf_we", 32'(rf_we), 32'd0);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule